// File: doc/BRIEF.md
# Three-Channel Doorbell Mailbox

This block lets two processors signal each other through three fixed channels on an APB register interface. Each channel holds a 32-bit status word, and every bit of that word can serve as its own doorbell. The sender writes a mask to a set port to raise bits, and a mask to a clear port to drop them. Either side can read the current word. The bits of each word are OR-reduced into one registered interrupt line toward the receiving processor.

No acknowledgement is generated automatically. A sender polls the status word, and the receiver clears the bits once it has consumed the message. Channel 0 is the low-priority non-secure link, channel 1 is the high-priority non-secure link, and channel 2 is reserved for secure masters. A non-secure access to channel 2 gets an error response and has no effect. Every access completes with no wait states.

Top module: `dbell_mbox`

## Requirements
- R1: After reset every status word is zero and all three interrupt outputs are low.
- R2: A write to a channel's set register (offset 0x08) ORs the written mask into that channel's status word. Zero bits in the mask leave the matching status bits unchanged.
- R3: A write to a channel's clear register (offset 0x10) clears every status bit that is 1 in the mask. Zero bits in the mask leave the matching status bits unchanged.
- R4: A read of a channel's status register (offset 0x00) returns its status word. Channel bases are 0x000, 0x020 and 0x200. Writes to the status offset are ignored, and reads of the set or clear offsets return zero.
- R5: irq_o[n] is the OR of channel n's status bits. It changes on the same clock edge as the status word, which is the edge that ends the write's access phase. It therefore goes low on the cycle after the last set bit is cleared.
- R6: A write to one channel never changes the status or interrupt of another channel.
- R7: A non-secure access (pprot_i[1]=1) to channel 2 reads as zero, is ignored on write, and asserts pslverr_o during its access phase. A secure access (pprot_i[1]=0) to channel 2 works normally, and non-secure accesses to channels 0 and 1 work normally.
- R8: pready_o is always high. pslverr_o is low for every access other than the case in R7.
- R9: An address that matches no channel register reads as zero, and a write to it changes no status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | APB peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write when high |
| paddr_i | input | 12 | APB byte address |
| pwdata_i | input | 32 | APB write data / bit mask |
| pprot_i | input | 3 | APB protection; bit 1 high marks a non-secure access |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| pslverr_o | output | 1 | APB error for a non-secure access to the secure channel |
| irq_o | output | 3 | Per-channel interrupt, index = channel |

## Verification
The assertions assume a well-formed APB master. Each transfer has a setup cycle with psel_i high and penable_i low, followed by exactly one access cycle. Address, write, data and protection inputs stay stable across both cycles. The bench drives every transfer through one task that builds exactly this two-cycle shape on the falling clock edge, and it inserts an idle cycle between transfers. As a result, no assertion ever sees a back-to-back or malformed access.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SPAN_W  = 5;       // bytes per channel window = 2**SPAN_W
  localparam logic [SPAN_W-1:0] OFS_STAT = 5'h00;
  localparam logic [SPAN_W-1:0] OFS_SET  = 5'h08;
  localparam logic [SPAN_W-1:0] OFS_CLR  = 5'h10;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_STAT = 2'd1,
    RK_SET  = 2'd2,
    RK_CLR  = 2'd3
  } reg_kind_e;

  // low-priority and high-priority links are packed; the secure link sits apart
  function automatic logic [31:0] chan_base(input int unsigned ch);
    if (ch < 2) return 32'(ch) << SPAN_W;
    return 32'h200;
  endfunction
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] paddr_i,
  output logic [NUM_CH-1:0] ch_hit_o,
  output reg_kind_e         kind_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    localparam logic [31:0] BASE = chan_base(i);
    assign ch_hit_o[i] = (paddr_i[ADDR_W-1:SPAN_W] == BASE[ADDR_W-1:SPAN_W]);
  end

  always_comb begin
    unique case (paddr_i[SPAN_W-1:0])
      OFS_STAT: kind_o = RK_STAT;
      OFS_SET:  kind_o = RK_SET;
      OFS_CLR:  kind_o = RK_CLR;
      default:  kind_o = RK_NONE;
    endcase
  end

  assert_onehot_hit_R4: assert final ($onehot0(ch_hit_o));
endmodule

// File: rtl/dbell_chan.sv
module dbell_chan
  import dbell_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic [WIDTH-1:0] status_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] status_q, status_d, set_m, clr_m;
  logic             irq_q;

  assign set_m    = set_en_i ? mask_i : '0;
  assign clr_m    = clr_en_i ? mask_i : '0;
  // clear wins over set on a shared bit
  assign status_d = (status_q | set_m) & ~clr_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= |status_d;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  assert_w1s_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_en_i && !clr_en_i) |=> ((status_q & $past(mask_i)) == $past(mask_i)));
  assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((status_q & $past(mask_i)) == '0));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_en_i && !clr_en_i) |=> $stable(status_q));
  assert_irq_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q == '0 && !set_en_i) |=> !irq_o);
  assert_irq_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q != '0 && !clr_en_i) |=> irq_o);
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox
  import dbell_pkg::*;
#(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SECURE_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  input  logic [2:0]        pprot_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] ch_hit, set_en, clr_en;
  logic [DATA_W-1:0] status [NUM_CH];
  logic [DATA_W-1:0] rd_part [NUM_CH];
  reg_kind_e         kind;
  logic              acc, nonsec, blocked, wr_ok, rd_ok;
  logic              unused_prot;

  assign unused_prot = ^{pprot_i[2], pprot_i[0]};

  dbell_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .paddr_i (paddr_i),
    .ch_hit_o(ch_hit),
    .kind_o  (kind)
  );

  assign acc     = psel_i & penable_i;
  assign nonsec  = pprot_i[1];
  assign blocked = nonsec & ch_hit[SECURE_CH];
  assign wr_ok   = acc & pwrite_i & ~blocked;
  assign rd_ok   = acc & ~pwrite_i & ~blocked;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign set_en[i]  = wr_ok & ch_hit[i] & (kind == RK_SET);
    assign clr_en[i]  = wr_ok & ch_hit[i] & (kind == RK_CLR);
    assign rd_part[i] = (rd_ok && ch_hit[i] && kind == RK_STAT) ? status[i] : '0;

    dbell_chan #(.WIDTH(DATA_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_en_i(set_en[i]),
      .clr_en_i(clr_en[i]),
      .mask_i  (pwdata_i),
      .status_o(status[i]),
      .irq_o   (irq_o[i])
    );
  end

  always_comb begin
    prdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) prdata_o |= rd_part[i];
  end

  assign pready_o  = 1'b1;
  assign pslverr_o = acc & blocked;

  assert_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni) pready_o);
  assert_sec_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && nonsec && ch_hit[SECURE_CH]) |=> $stable(status[SECURE_CH]));
  assert_sec_rd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> (prdata_o == '0));
  assert_err_scope_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !nonsec) |-> !pslverr_o);
endmodule

// File: tb/dbell_mbox_tb.sv
module dbell_mbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [2:0]  pprot = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [2:0]  irq;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] model [3];
  logic [31:0] rd;
  logic        err;

  always #2 clk = ~clk;

  dbell_mbox u_dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .pprot_i(pprot),
    .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr), .irq_o(irq)
  );

  function automatic logic [11:0] base(int ch);
    return (ch < 2) ? 12'(ch * 32) : 12'h200;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // two-cycle APB transfer; returns read data and error sampled in the access phase
  task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     input logic ns, output logic [31:0] r, output logic e);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pprot = {1'b0, ns, 1'b0};
    @(negedge clk);
    penable = 1'b1;
    #1;
    r = prdata; e = pslverr;
    check("R8 ready", {31'b0, pready}, 32'd1);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic check_all(string req);
    logic [31:0] r; logic e;
    for (int c = 0; c < 3; c++) begin
      apb(1'b0, base(c), 32'h0, 1'b0, r, e);
      check({req, " stat"}, r, model[c]);
      check({req, " irq"}, {31'b0, irq[c]}, {31'b0, |model[c]});
    end
  endtask

  initial begin
    for (int c = 0; c < 3; c++) model[c] = '0;
    repeat (3) @(negedge clk);
    check("R1 irq reset", {29'b0, irq}, 32'd0);
    rst_n = 1'b1;
    check_all("R1");

    // single-bit sweep on each channel: set, observe, clear, observe
    for (int c = 0; c < 3; c++) begin
      for (int b = 0; b < 32; b++) begin
        apb(1'b1, base(c) + 12'h08, 32'd1 << b, 1'b0, rd, err);
        model[c] |= 32'd1 << b;
        check("R2 set", {31'b0, err}, 32'd0);
        check("R5 irq after set", {31'b0, irq[c]}, 32'd1);
        apb(1'b0, base(c), 32'h0, 1'b0, rd, err);
        check("R4 stat read", rd, model[c]);
      end
      check_all("R6 after sweep");
      for (int b = 0; b < 32; b++) begin
        apb(1'b1, base(c) + 12'h10, 32'd1 << b, 1'b0, rd, err);
        model[c] &= ~(32'd1 << b);
        check("R5 irq after clear", {31'b0, irq[c]}, {31'b0, b != 31});
        apb(1'b0, base(c), 32'h0, 1'b0, rd, err);
        check("R3 clear", rd, model[c]);
      end
    end

    // mask patterns
    apb(1'b1, base(0) + 12'h08, 32'hA5A5_0F0F, 1'b0, rd, err); model[0] |= 32'hA5A5_0F0F;
    apb(1'b1, base(1) + 12'h08, 32'h8000_0001, 1'b0, rd, err); model[1] |= 32'h8000_0001;
    check_all("R6 patterns");
    apb(1'b1, base(0) + 12'h08, 32'h0, 1'b0, rd, err);
    check_all("R2 zero set mask");
    apb(1'b1, base(0) + 12'h10, 32'h0, 1'b0, rd, err);
    check_all("R3 zero clear mask");
    apb(1'b1, base(0) + 12'h10, 32'h0505_FFFF, 1'b0, rd, err); model[0] &= ~32'h0505_FFFF;
    check_all("R3 partial clear");
    apb(1'b1, base(0), 32'hFFFF_FFFF, 1'b0, rd, err);
    check_all("R4 stat write ignored");
    apb(1'b0, base(0) + 12'h08, 32'h0, 1'b0, rd, err);
    check("R4 set reads zero", rd, 32'h0);
    apb(1'b0, base(0) + 12'h10, 32'h0, 1'b0, rd, err);
    check("R4 clear reads zero", rd, 32'h0);

    // unmapped
    apb(1'b1, 12'h048, 32'hFFFF_FFFF, 1'b0, rd, err);
    apb(1'b1, 12'h00C, 32'hFFFF_FFFF, 1'b0, rd, err);
    apb(1'b1, 12'h218, 32'hFFFF_FFFF, 1'b0, rd, err);
    check_all("R9 unmapped write");
    apb(1'b0, 12'h044, 32'h0, 1'b0, rd, err);
    check("R9 unmapped read", rd, 32'h0);
    check("R8 no err unmapped", {31'b0, err}, 32'd0);

    // secure channel gating
    apb(1'b1, base(2) + 12'h08, 32'h0000_00F0, 1'b0, rd, err); model[2] |= 32'h0000_00F0;
    check("R7 secure write ok", {31'b0, err}, 32'd0);
    apb(1'b1, base(2) + 12'h08, 32'h0F00_0000, 1'b1, rd, err);
    check("R7 ns set err", {31'b0, err}, 32'd1);
    apb(1'b1, base(2) + 12'h10, 32'hFFFF_FFFF, 1'b1, rd, err);
    check("R7 ns clear err", {31'b0, err}, 32'd1);
    apb(1'b0, base(2), 32'h0, 1'b1, rd, err);
    check("R7 ns read zero", rd, 32'h0);
    check("R7 ns read err", {31'b0, err}, 32'd1);
    check_all("R7 ns writes ignored");
    apb(1'b1, base(1) + 12'h08, 32'h0000_1000, 1'b1, rd, err); model[1] |= 32'h0000_1000;
    check("R7 ns ch1 no err", {31'b0, err}, 32'd0);
    apb(1'b0, base(0), 32'h0, 1'b1, rd, err);
    check("R7 ns ch0 read", rd, model[0]);
    check_all("R7 ns low channels");
    for (int c = 0; c < 3; c++) begin
      apb(1'b1, base(c) + 12'h10, 32'hFFFF_FFFF, 1'b0, rd, err);
      model[c] = '0;
    end
    check_all("R5 all cleared");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog got=%0d exp=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule